// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer with Waveform Outputs

This block is an 8-bit timer/counter that advances on a qualified count-enable pulse from an external prescaler. It also produces two waveform outputs. A 3-bit mode input selects one of four behaviours:

- free-running count;
- clear-on-compare, where compare value A sets the period;
- single-slope (fast) PWM;
- dual-slope (phase-correct) PWM.

Each PWM family has two variants, with the period end at 0xFF or at compare value A. Two reserved encodings freeze the timer.

Two compare channels, A and B, each hold a write buffer and an active compare value. Each has a 2-bit output code that decides how its pin reacts to a match. When the buffer moves into the active value depends on the mode, so a PWM duty change never lands mid-period. Three sticky event flags record overflow, compare A and compare B. They stay set until the matching bit is written as 1 on the clear input.

Top module: `wavegen_timer8`

## Requirements
- R1: Synchronous reset clears the counter, the direction state, both buffers, both active compare values, all three flags and both waveform outputs.
- R2: The counter changes only on clock edges where `tick` is 1. Mode codes 100 and 110 are reserved: in them the counter, waves and flags all hold even with `tick` high.
- R3: Modes 000 (normal) and 011 (fast PWM) count up to 0xFF. Modes 010 (clear-on-compare) and 111 (fast PWM) count up to the active compare A value. On the tick at that end value the counter goes to 0.
- R4: Modes 001 (end 0xFF) and 101 (end = active compare A) count 0 up to the end value and back down to 0. Direction reverses in one tick, and neither end value is repeated.
- R5: In modes 000, 010 and the reserved modes a compare write reaches the active value on the next edge. In fast PWM the buffer is copied on the tick where the counter wraps. In phase-correct PWM it is copied on the tick where the counter sits at its end value.
- R6: The overflow flag is set on the tick where the count is 0xFF in modes 000, 010 and 011. In mode 111 it is set on the tick at the end value. In phase-correct modes it is set on the tick at 0 reached while counting down.
- R7: A compare flag is set on any tick where the count equals that channel's active value. Flags stay set until `flag_clr` has a 1 at their bit: bit 0 for overflow, bit 1 for A, bit 2 for B. A set event wins over a clear in the same cycle.
- R8: Output code 00 holds the pin low in every mode. In modes 000 and 010 a match toggles the pin for code 01, clears it for code 10 and sets it for code 11.
- R9: In fast PWM, code 10 clears the pin on a match and sets it on the wrap tick, with the wrap winning on a tie. Code 11 is the inverse. Code 01 drives low.
- R10: In phase-correct PWM, code 10 clears the pin on a match while the counter is about to move up and sets it on a match while about to move down. Code 11 is the inverse. Code 01 drives low. At 0 the next move is up; at the end value it is down.
- R11: In phase-correct PWM a compare value equal to the end value gives a constant level: high for code 10, low for code 11. A compare value of 0 gives low for code 10 and high for code 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count enable |
| mode_sel | input | 3 | Mode code |
| com_a | input | 2 | Output code, channel A |
| com_b | input | 2 | Output code, channel B |
| cmp_a_wr | input | 1 | Write strobe, compare A |
| cmp_a_data | input | 8 | Write data, compare A |
| cmp_b_wr | input | 1 | Write strobe, compare B |
| cmp_b_data | input | 8 | Write data, compare B |
| flag_clr | input | 3 | Write-1-to-clear: bit 0 overflow, bit 1 A, bit 2 B |
| count_o | output | 8 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_a_flag | output | 1 | Sticky compare A flag |
| cmp_b_flag | output | 1 | Sticky compare B flag |
| wave_a | output | 1 | Waveform A |
| wave_b | output | 1 | Waveform B |

## Verification
The bench changes the compare A value in the middle of a period in fast, phase-correct and clear-on-compare modes. If the design loaded the buffer at the wrong point, the period would end at the new value too early, or too late in the immediate mode. Phase-correct runs are sampled just after both turning points. These catch a counter that repeats an end value, an overflow flag raised at the wrong end, and a pin that ignores direction. Compare values at the end value and at 0 must give steady levels; a design that toggled there would show a pulse train. The reserved codes, a zero period after reset, idle cycles without `tick`, and per-bit flag clearing are each probed at the ports.

// File: rtl/wgt_pkg.sv
package wgt_pkg;
  localparam logic [2:0] MODE_FREE  = 3'd0;
  localparam logic [2:0] MODE_PC_FF = 3'd1;
  localparam logic [2:0] MODE_CLRCMP = 3'd2;
  localparam logic [2:0] MODE_FP_FF = 3'd3;
  localparam logic [2:0] MODE_RSV_A = 3'd4;
  localparam logic [2:0] MODE_PC_A  = 3'd5;
  localparam logic [2:0] MODE_RSV_B = 3'd6;
  localparam logic [2:0] MODE_FP_A  = 3'd7;

  localparam logic [1:0] COM_OFF  = 2'b00;
  localparam logic [1:0] COM_ALT  = 2'b01;
  localparam logic [1:0] COM_LOW  = 2'b10;
  localparam logic [1:0] COM_HIGH = 2'b11;

  localparam int NUM_CH = 2;
endpackage

// File: rtl/wgt_counter.sv
module wgt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         phase,
  input  logic [W-1:0] top,
  output logic [W-1:0] count,
  output logic         dir_dn,
  output logic         nxt_up,
  output logic         at_top
);
  localparam logic [W-1:0] BOT = '0;

  always_comb begin
    at_top = (count == top);
    if (count == BOT)      nxt_up = 1'b1;
    else if (count >= top) nxt_up = 1'b0;
    else                   nxt_up = !dir_dn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= BOT;
      dir_dn <= 1'b0;
    end else if (step) begin
      if (phase) begin
        if (top == BOT)  count <= BOT;
        else if (nxt_up) count <= count + 1'b1;
        else             count <= count - 1'b1;
        dir_dn <= !nxt_up;
      end else begin
        count  <= at_top ? BOT : count + 1'b1;
        dir_dn <= 1'b0;
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count)); // R2
  AST_WRAP_TO_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    step && !phase && at_top |=> count == BOT); // R3
  AST_PC_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
    step && phase && (top != BOT) |=>
      ((count - $past(count)) == 1) || (($past(count) - count) == 1)); // R4
endmodule

// File: rtl/wgt_cmp_chan.sv
module wgt_cmp_chan
  import wgt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         imm,
  input  logic         load,
  input  logic         fast,
  input  logic         phase,
  input  logic [1:0]   com,
  input  logic [W-1:0] count,
  input  logic         wrap,
  input  logic         nxt_up,
  output logic [W-1:0] ocr,
  output logic         match,
  output logic         wave
);
  logic [W-1:0] shadow;

  assign match = (count == ocr);

  always_ff @(posedge clk) begin
    if (rst)     shadow <= '0;
    else if (wr) shadow <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)            ocr <= '0;
    else if (imm && wr) ocr <= wdata;
    else if (load)      ocr <= shadow;
  end

  always_ff @(posedge clk) begin
    if (rst || com == COM_OFF) begin
      wave <= 1'b0;
    end else if (step) begin
      if (fast) begin
        if (com == COM_ALT) wave <= 1'b0;
        else if (wrap)      wave <= (com == COM_LOW);
        else if (match)     wave <= (com == COM_HIGH);
      end else if (phase) begin
        if (com == COM_ALT) wave <= 1'b0;
        else if (match)     wave <= (com == COM_LOW) ? !nxt_up : nxt_up;
      end else if (match) begin
        case (com)
          COM_ALT: wave <= !wave;
          COM_LOW: wave <= 1'b0;
          default: wave <= 1'b1;
        endcase
      end
    end
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    com == COM_OFF |=> !wave); // R8
  AST_IMM_WRITE: assert property (@(posedge clk) disable iff (rst)
    imm && wr |=> ocr == $past(wdata)); // R5
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(imm && wr) && !load |=> $stable(ocr)); // R5
endmodule

// File: rtl/wavegen_timer8.sv
module wavegen_timer8
  import wgt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [2:0]   mode_sel,
  input  logic [1:0]   com_a,
  input  logic [1:0]   com_b,
  input  logic         cmp_a_wr,
  input  logic [W-1:0] cmp_a_data,
  input  logic         cmp_b_wr,
  input  logic [W-1:0] cmp_b_data,
  input  logic [2:0]   flag_clr,
  output logic [W-1:0] count_o,
  output logic         ovf_flag,
  output logic         cmp_a_flag,
  output logic         cmp_b_flag,
  output logic         wave_a,
  output logic         wave_b
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] BOT  = '0;
  localparam int NF = NUM_CH + 1;

  logic run, step, phase, fast, imm, top_from_a;
  logic [W-1:0] top_val, count;
  logic dir_dn, nxt_up, at_top, load, ovf_ev;
  logic [NUM_CH-1:0]        wr_v, match_v, wave_v;
  logic [NUM_CH-1:0][W-1:0] data_v, ocr_v;
  logic [NUM_CH-1:0][1:0]   com_v;
  logic [NF-1:0] ev, flags;

  always_comb begin
    run        = !(mode_sel == MODE_RSV_A || mode_sel == MODE_RSV_B);
    step       = tick && run;
    phase      = (mode_sel == MODE_PC_FF) || (mode_sel == MODE_PC_A);
    fast       = (mode_sel == MODE_FP_FF) || (mode_sel == MODE_FP_A);
    imm        = !phase && !fast;
    top_from_a = (mode_sel == MODE_CLRCMP) || (mode_sel == MODE_PC_A) ||
                 (mode_sel == MODE_FP_A);
    top_val    = top_from_a ? ocr_v[0] : MAXV;
    load       = step && at_top && (fast || phase);
    if (phase)                        ovf_ev = step && (count == BOT) && dir_dn;
    else if (mode_sel == MODE_FP_A)   ovf_ev = step && at_top;
    else                              ovf_ev = step && (count == MAXV);
  end

  assign wr_v   = {cmp_b_wr, cmp_a_wr};
  assign data_v = {cmp_b_data, cmp_a_data};
  assign com_v  = {com_b, com_a};

  wgt_counter #(.W(W)) cnt_u (
    .clk(clk), .rst(rst), .step(step), .phase(phase), .top(top_val),
    .count(count), .dir_dn(dir_dn), .nxt_up(nxt_up), .at_top(at_top)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wgt_cmp_chan #(.W(W)) ch_u (
      .clk(clk), .rst(rst), .step(step), .wr(wr_v[c]), .wdata(data_v[c]),
      .imm(imm), .load(load), .fast(fast), .phase(phase), .com(com_v[c]),
      .count(count), .wrap(at_top), .nxt_up(nxt_up),
      .ocr(ocr_v[c]), .match(match_v[c]), .wave(wave_v[c])
    );
    assign ev[c+1] = step && match_v[c];
  end
  assign ev[0] = ovf_ev;

  for (genvar f = 0; f < NF; f++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)              flags[f] <= 1'b0;
      else if (ev[f])       flags[f] <= 1'b1;
      else if (flag_clr[f]) flags[f] <= 1'b0;
    end
  end

  assign count_o    = count;
  assign ovf_flag   = flags[0];
  assign cmp_a_flag = flags[1];
  assign cmp_b_flag = flags[2];
  assign wave_a     = wave_v[0];
  assign wave_b     = wave_v[1];

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !flag_clr[0] |=> ovf_flag); // R7
  AST_RSV_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(count_o) && $stable(wave_a) && $stable(wave_b)); // R2
endmodule

// File: tb/wavegen_timer8_tb_top.sv
`timescale 1ns/1ps
module wavegen_timer8_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b0;
  logic tick = 1'b0;
  logic [2:0] mode_sel = 3'd0;
  logic [1:0] com_a = 2'd0, com_b = 2'd0;
  logic cmp_a_wr = 1'b0, cmp_b_wr = 1'b0;
  logic [7:0] cmp_a_data = 8'd0, cmp_b_data = 8'd0;
  logic [2:0] flag_clr = 3'd0;
  logic [7:0] count_o;
  logic ovf_flag, cmp_a_flag, cmp_b_flag, wave_a, wave_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wavegen_timer8 #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .mode_sel(mode_sel),
    .com_a(com_a), .com_b(com_b),
    .cmp_a_wr(cmp_a_wr), .cmp_a_data(cmp_a_data),
    .cmp_b_wr(cmp_b_wr), .cmp_b_data(cmp_b_data),
    .flag_clr(flag_clr), .count_o(count_o), .ovf_flag(ovf_flag),
    .cmp_a_flag(cmp_a_flag), .cmp_b_flag(cmp_b_flag),
    .wave_a(wave_a), .wave_b(wave_b)
  );

  typedef struct packed {
    logic [2:0]  mode;
    logic [7:0]  ocra;
    logic [1:0]  coma;
    logic [7:0]  ocrb;
    logic [1:0]  comb;
    logic [15:0] n;
    logic [7:0]  cnt;
    logic        wa;
    logic        wb;
    logic        ovf;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 8'd4,   2'b01, 8'd2,  2'b11, 16'd9,   8'd4,   1'b1, 1'b1, 1'b0},
    '{3'd7, 8'd5,   2'b00, 8'd2,  2'b10, 16'd8,   8'd2,   1'b0, 1'b1, 1'b1},
    '{3'd7, 8'd5,   2'b00, 8'd2,  2'b10, 16'd9,   8'd3,   1'b0, 1'b0, 1'b1},
    '{3'd3, 8'd0,   2'b10, 8'd20, 2'b11, 16'd300, 8'd44,  1'b0, 1'b1, 1'b1},
    '{3'd5, 8'd4,   2'b10, 8'd2,  2'b10, 16'd5,   8'd3,   1'b1, 1'b0, 1'b0},
    '{3'd5, 8'd4,   2'b10, 8'd2,  2'b10, 16'd7,   8'd1,   1'b1, 1'b1, 1'b0},
    '{3'd5, 8'd4,   2'b10, 8'd2,  2'b10, 16'd9,   8'd1,   1'b1, 1'b1, 1'b1},
    '{3'd5, 8'd4,   2'b11, 8'd4,  2'b10, 16'd12,  8'd4,   1'b0, 1'b1, 1'b1},
    '{3'd5, 8'd4,   2'b00, 8'd0,  2'b11, 16'd12,  8'd4,   1'b0, 1'b1, 1'b1},
    '{3'd0, 8'd3,   2'b01, 8'd0,  2'b10, 16'd4,   8'd4,   1'b1, 1'b0, 1'b0},
    '{3'd0, 8'd3,   2'b01, 8'd5,  2'b11, 16'd256, 8'd0,   1'b1, 1'b1, 1'b1},
    '{3'd4, 8'd3,   2'b11, 8'd0,  2'b11, 16'd5,   8'd0,   1'b0, 1'b0, 1'b0},
    '{3'd1, 8'h80,  2'b11, 8'd0,  2'b00, 16'd300, 8'd210, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    mode_sel = 3'd0; com_a = 2'd0; com_b = 2'd0; tick = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_a(logic [7:0] v);
    @(negedge clk);
    cmp_a_wr = 1'b1; cmp_a_data = v;
    @(negedge clk);
    cmp_a_wr = 1'b0;
  endtask

  task automatic wr_b(logic [7:0] v);
    @(negedge clk);
    cmp_b_wr = 1'b1; cmp_b_data = v;
    @(negedge clk);
    cmp_b_wr = 1'b0;
  endtask

  task automatic run_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic string mode_req(logic [2:0] m);
    if (m == 3'd1 || m == 3'd5) return "R4 R10 R11";
    if (m == 3'd3 || m == 3'd7) return "R3 R9";
    if (m == 3'd4 || m == 3'd6) return "R2";
    return "R3 R8";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    chk("R1 count", count_o, 0);
    chk("R1 flags", {ovf_flag, cmp_a_flag, cmp_b_flag}, 0);
    chk("R1 waves", {wave_a, wave_b}, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr_a(VECS[v].ocra);
      wr_b(VECS[v].ocrb);
      @(negedge clk);
      mode_sel = VECS[v].mode; com_a = VECS[v].coma; com_b = VECS[v].comb;
      run_ticks(int'(VECS[v].n));
      chk($sformatf("%s vec%0d count", mode_req(VECS[v].mode), v), count_o, int'(VECS[v].cnt));
      chk($sformatf("%s vec%0d wave_a", mode_req(VECS[v].mode), v), wave_a, VECS[v].wa);
      chk($sformatf("%s vec%0d wave_b", mode_req(VECS[v].mode), v), wave_b, VECS[v].wb);
      chk($sformatf("R6 vec%0d ovf", v), ovf_flag, VECS[v].ovf);
    end

    // R1: compare A cleared by reset -> clear-on-compare period of one
    do_reset();
    @(negedge clk); mode_sel = 3'd2;
    run_ticks(3);
    chk("R1 ocra reset gives zero top", count_o, 0);

    // R2: no tick, no movement
    do_reset();
    run_ticks(3);
    repeat (5) @(negedge clk);
    chk("R2 idle hold", count_o, 3);

    // R5: fast PWM buffered write of period
    do_reset();
    wr_a(8'd5);
    @(negedge clk); mode_sel = 3'd7;
    run_ticks(2);
    wr_a(8'd2);
    run_ticks(3);
    chk("R5 fast old top kept", count_o, 5);
    run_ticks(1);
    chk("R5 fast wrap", count_o, 0);
    run_ticks(3);
    chk("R5 fast new top", count_o, 0);

    // R5: clear-on-compare immediate write
    do_reset();
    wr_a(8'd9);
    @(negedge clk); mode_sel = 3'd2;
    run_ticks(3);
    wr_a(8'd4);
    run_ticks(2);
    chk("R5 immediate top", count_o, 0);

    // R5 R4: phase-correct copy at end value
    do_reset();
    wr_a(8'd4);
    @(negedge clk); mode_sel = 3'd5;
    run_ticks(1);
    wr_a(8'd6);
    run_ticks(4);
    chk("R5 phase turn at old top", count_o, 3);
    run_ticks(10);
    chk("R4 phase turn at new top", count_o, 5);

    // R7: sticky flags and per-bit clear
    do_reset();
    wr_a(8'd5);
    wr_b(8'd2);
    @(negedge clk); mode_sel = 3'd7;
    run_ticks(8);
    repeat (3) @(negedge clk);
    chk("R7 flags sticky", {ovf_flag, cmp_a_flag, cmp_b_flag}, 3'b111);
    flag_clr = 3'b001;
    @(negedge clk); flag_clr = 3'b000;
    chk("R7 clear overflow only", {ovf_flag, cmp_a_flag, cmp_b_flag}, 3'b011);
    flag_clr = 3'b110;
    @(negedge clk); flag_clr = 3'b000;
    chk("R7 clear compare flags", {ovf_flag, cmp_a_flag, cmp_b_flag}, 3'b000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule